// File: doc/BRIEF.md
# Parallel EEPROM Byte Writer with Completion Polling

This block sits on the host side of an asynchronous parallel EEPROM with an 11-bit address and a byte-wide data bus. It accepts one request at a time. A write request sets the strobes for a self-timed byte program. The block then finds the end of the internal write by reading the same location again and again. While the device is busy it returns the inverse of the written bit 7. The block compares only that bit. Once bit 7 agrees with the written value, one more read checks the whole byte. The block then reports success or failure. A read request performs a single read cycle and returns the byte.

All strobe timing is counted in clock cycles. The parameters are the address setup before the write strobe, the write strobe width, the access time, the output-enable delay and the standby gap between accesses. The write strobe width is never shorter than the clock count that exceeds 10 ns.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The fields must be held stable while `req_valid` is high and `req_ready` is low. `req_ready` drops at acceptance. It returns one cycle after the `done` or `error` pulse, so only one request is in flight. Nothing pushes back on the result pulses. `done` and `error` are plain single-cycle outputs that the host must sample when they occur.

Top module: `pmem_wpoll`

## Requirements
- R1: `req_ready` is high when idle and low from the cycle after acceptance up to and including the cycle of the `done`/`error` pulse. It is high again in the following cycle.
- R2: During a write, `mem_ce_n` is low and `mem_oe_n` is high. `mem_we_n` is low for at least max(WE_PULSE_CYC, WE_MIN_NS/CLK_NS+1) cycles. `mem_addr` does not change while `mem_we_n` is low. `mem_dq_oe` is high with the request data on `mem_dq_o` in the cycle where `mem_we_n` rises.
- R3: A read holds `mem_ce_n` low and `mem_we_n` high. The address is stable with CE low for at least ACC_CYC-OE_CYC cycles (minimum 1) before `mem_oe_n` falls. The byte is sampled at the end of the OE_CYC-th cycle with `mem_oe_n` low.
- R4: `mem_dq_oe` is never high while `mem_oe_n` is low. It is already low in the cycle before `mem_oe_n` falls.
- R5: `mem_ce_n` goes high between any two accesses, so each CE-low window contains exactly one write strobe or one OE-low period. After reset, and whenever idle, all three strobes are high and `mem_dq_oe` is low.
- R6: After a write, the block reads the written address and compares only bit 7 with bit 7 of the written byte. Bits 6..0 of a poll result have no effect on when polling stops.
- R7: If MAX_POLLS consecutive polls all return a bit 7 that differs from the written bit 7, the block pulses `error` and performs no further read for that request.
- R8: After a matching poll, exactly one further read of the same address is made. `done` is pulsed if all 8 bits equal the written byte, otherwise `error` is pulsed.
- R9: A read request (`req_write`=0) performs exactly one read cycle and pulses `done`, with `rd_data` holding the sampled byte in that cycle.
- R10: `done` and `error` are never high together, and each is high for one cycle per request.
- R11: A bit-7 match on the MAX_POLLS-th poll counts as success: the verify read follows, and no timeout error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready; high only when idle |
| req_write | input | 1 | 1 = byte write with polling, 0 = single read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| done | output | 1 | One-cycle pulse: request finished successfully |
| error | output | 1 | One-cycle pulse: poll timeout or verify mismatch |
| rd_data | output | DATA_W | Last byte sampled from the device |
| mem_ce_n | output | 1 | Device chip enable, active low |
| mem_oe_n | output | 1 | Device output enable, active low |
| mem_we_n | output | 1 | Device write enable, active low |
| mem_addr | output | ADDR_W | Device address bus |
| mem_dq_o | output | DATA_W | Data driven toward the device |
| mem_dq_oe | output | 1 | Enable for the data bus driver |
| mem_dq_i | input | DATA_W | Data read from the device bus |

## Verification
The timeout decision and the bit-7 match can land on the same poll: the last permitted read. The bench's device model stays busy for a set number of reads. If it stays busy for MAX_POLLS-1 reads, the match arrives exactly on the final poll. The expected outcome is `done`, after MAX_POLLS+1 reads in total. A model that stays busy for MAX_POLLS reads must instead give `error` after exactly MAX_POLLS reads. The read count seen at the device pins separates the two cases, and it also catches a comparator that looks at more than bit 7.

// File: rtl/pmw_pkg.sv
package pmw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_GAP,
    ST_RPRE,
    ST_ROE,
    ST_EVAL,
    ST_RESP
  } pmw_state_e;

  typedef enum logic [1:0] {
    K_RAND,
    K_POLL,
    K_VERIFY
  } pmw_kind_e;

  function automatic int pmw_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pmw_timer.sv
module pmw_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);

  // R3: once expired and not reloaded, the timer stays expired
  a_r3_timer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && last) |=> last);

endmodule

// File: rtl/pmw_poll_cnt.sv
module pmw_poll_cnt #(
  parameter int MAX_POLLS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (inc)    cnt <= cnt + 1'b1;
  end

  assign at_limit = (cnt == CW'(MAX_POLLS - 1));

  // R7: the poll index never passes the last permitted poll
  a_r7_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAX_POLLS - 1));

  // R7: no further poll is requested once the limit poll has been made
  a_r7_no_inc_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !at_limit);

endmodule

// File: rtl/pmw_cmp.sv
module pmw_cmp #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] exp_byte,
  input  logic [DW-1:0] got_byte,
  output logic          msb_ok,
  output logic          all_ok
);
  assign msb_ok = (exp_byte[DW-1] == got_byte[DW-1]);
  assign all_ok = (exp_byte == got_byte);
endmodule

// File: rtl/pmem_wpoll.sv
module pmem_wpoll #(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int CLK_NS       = 8,
  parameter int WE_MIN_NS    = 10,
  parameter int WE_PULSE_CYC = 2,
  parameter int SETUP_CYC    = 1,
  parameter int ACC_CYC      = 4,
  parameter int OE_CYC       = 2,
  parameter int GAP_CYC      = 1,
  parameter int MAX_POLLS    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic              error,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  import pmw_pkg::*;

  localparam int WE_MIN_CYC = WE_MIN_NS / CLK_NS + 1;
  localparam int WE_CYC     = pmw_max(WE_PULSE_CYC, WE_MIN_CYC);
  localparam int SET_CYC    = pmw_max(SETUP_CYC, 1);
  localparam int GAP_EFF    = pmw_max(GAP_CYC, 1);
  localparam int OE_EFF     = pmw_max(OE_CYC, 1);
  localparam int PRE_CYC    = (ACC_CYC > OE_EFF) ? (ACC_CYC - OE_EFF) : 1;
  localparam int T_MAX      = pmw_max(pmw_max(WE_CYC, SET_CYC),
                                      pmw_max(pmw_max(GAP_EFF, OE_EFF), PRE_CYC));
  localparam int TW         = $clog2(T_MAX + 1);
  localparam int RW         = $clog2(WE_CYC + 2) + 1;

  pmw_state_e st_q, st_d;
  pmw_kind_e  kind_q, kind_d;
  logic       resp_err_q, resp_err_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_q;

  logic          accept;
  logic          pc_clear, pc_inc, at_limit;
  logic          t_last, t_load;
  logic [TW-1:0] t_len;
  logic          msb_ok, all_ok;

  // ---------------- sub-blocks ----------------
  pmw_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_len),
    .last     (t_last)
  );

  pmw_poll_cnt #(.MAX_POLLS(MAX_POLLS)) u_polls (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (pc_clear),
    .inc      (pc_inc),
    .at_limit (at_limit)
  );

  pmw_cmp #(.DW(DATA_W)) u_cmp (
    .exp_byte (wdata_q),
    .got_byte (rd_q),
    .msb_ok   (msb_ok),
    .all_ok   (all_ok)
  );

  // ---------------- next state ----------------
  always_comb begin
    st_d       = st_q;
    kind_d     = kind_q;
    resp_err_d = resp_err_q;
    accept     = 1'b0;
    pc_clear   = 1'b0;
    pc_inc     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          pc_clear = 1'b1;
          kind_d   = req_write ? K_POLL : K_RAND;
          st_d     = req_write ? ST_WSETUP : ST_RPRE;
        end
      end
      ST_WSETUP: if (t_last) st_d = ST_WPULSE;
      ST_WPULSE: if (t_last) st_d = ST_WHOLD;
      ST_WHOLD:  if (t_last) st_d = ST_GAP;
      ST_GAP:    if (t_last) st_d = ST_RPRE;
      ST_RPRE:   if (t_last) st_d = ST_ROE;
      ST_ROE:    if (t_last) st_d = ST_EVAL;
      ST_EVAL: begin
        unique case (kind_q)
          K_RAND: begin
            resp_err_d = 1'b0;
            st_d       = ST_RESP;
          end
          K_POLL: begin
            if (msb_ok) begin
              kind_d = K_VERIFY;
              st_d   = ST_GAP;
            end else if (at_limit) begin
              resp_err_d = 1'b1;
              st_d       = ST_RESP;
            end else begin
              pc_inc = 1'b1;
              st_d   = ST_GAP;
            end
          end
          K_VERIFY: begin
            resp_err_d = ~all_ok;
            st_d       = ST_RESP;
          end
          default: st_d = ST_RESP;
        endcase
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // timer reload on every state change with the new state's length
  assign t_load = (st_d != st_q);

  always_comb begin
    unique case (st_d)
      ST_WSETUP: t_len = TW'(SET_CYC - 1);
      ST_WPULSE: t_len = TW'(WE_CYC - 1);
      ST_GAP:    t_len = TW'(GAP_EFF - 1);
      ST_RPRE:   t_len = TW'(PRE_CYC - 1);
      ST_ROE:    t_len = TW'(OE_EFF - 1);
      default:   t_len = '0;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      kind_q     <= K_RAND;
      resp_err_q <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      rd_q       <= '0;
    end else begin
      st_q       <= st_d;
      kind_q     <= kind_d;
      resp_err_q <= resp_err_d;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (st_q == ST_ROE && t_last) rd_q <= mem_dq_i;
    end
  end

  // ---------------- outputs ----------------
  assign req_ready = (st_q == ST_IDLE);
  assign done      = (st_q == ST_RESP) && !resp_err_q;
  assign error     = (st_q == ST_RESP) &&  resp_err_q;
  assign rd_data   = rd_q;

  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = (st_q == ST_WSETUP) || (st_q == ST_WPULSE) || (st_q == ST_WHOLD);
  assign mem_we_n  = (st_q != ST_WPULSE);
  assign mem_oe_n  = (st_q != ST_ROE);
  assign mem_ce_n  = !((st_q == ST_WSETUP) || (st_q == ST_WPULSE) || (st_q == ST_WHOLD) ||
                       (st_q == ST_RPRE)   || (st_q == ST_ROE));

  // ---------------- assertions ----------------
  logic [RW-1:0] we_run;
  always_ff @(posedge clk) begin
    if (!rst_n)                     we_run <= '0;
    else if (mem_we_n)              we_run <= '0;
    else if (we_run != {RW{1'b1}})  we_run <= we_run + 1'b1;
  end

  a_r2_we_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> $stable(mem_addr));

  a_r2_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run >= RW'(WE_MIN_CYC)));

  a_r2_data_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  a_r4_release_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  a_r5_standby_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> mem_ce_n);

  a_r5_standby_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_oe) |-> mem_ce_n);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r1_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |=> req_ready);

endmodule

// File: tb/pmem_wpoll_tb_top.sv
module pmem_wpoll_tb_top;

  localparam int AW    = 11;
  localparam int DW    = 8;
  localparam int MAXP  = 4;
  localparam int OEC   = 2;
  localparam int ACC   = 4;
  localparam int WEMIN = 2;   // cycles of 8 ns that exceed 10 ns

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          done, error;
  logic [DW-1:0] rd_data;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_o, mem_dq_i;

  pmem_wpoll #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_NS(8), .WE_MIN_NS(10), .WE_PULSE_CYC(2),
    .SETUP_CYC(1), .ACC_CYC(ACC), .OE_CYC(OEC), .GAP_CYC(1), .MAX_POLLS(MAXP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .error(error), .rd_data(rd_data),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  int checks = 0;
  int errs   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [DW-1:0] mem [0:(1<<AW)-1];
  int            busy_cfg = 0;
  bit            corrupt  = 1'b0;
  int            busy_left = 0;
  logic [AW-1:0] busy_addr = '0;
  logic [DW-1:0] busy_data = '0;
  int            reads = 0;
  int            v_wr = 0, v_rd = 0, v_bus = 0, v_sb = 0;
  int            oe_cnt = 0, we_cnt = 0, pre_cnt = 0, acc_in_win = 0;
  logic          prev_we = 1'b1, prev_oe = 1'b1;
  logic [AW-1:0] prev_addr = '0, we_addr = '0;
  logic [DW-1:0] rd_val = '0;

  assign mem_dq_i = (!mem_ce_n && !mem_oe_n && oe_cnt >= OEC) ? rd_val : 8'h3C;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_oe_n && mem_dq_oe) v_bus++;
      if (mem_ce_n)                    pre_cnt = 0;
      else if (mem_addr != prev_addr)  pre_cnt = 1;
      else if (mem_oe_n)               pre_cnt++;
      if (mem_ce_n) acc_in_win = 0;
      if (!mem_we_n) begin
        if (mem_ce_n || !mem_oe_n) v_wr++;
        if (prev_we) begin
          we_addr = mem_addr;
          we_cnt  = 0;
          acc_in_win++;
        end
        we_cnt++;
        if (mem_addr != we_addr) v_wr++;
      end
      if (!prev_we && mem_we_n) begin
        if (we_cnt < WEMIN) v_wr++;
        if (!mem_dq_oe)     v_wr++;
        mem[we_addr] = corrupt ? (mem_dq_o ^ 8'h01) : mem_dq_o;
        busy_left = busy_cfg;
        busy_addr = we_addr;
        busy_data = mem_dq_o;
      end
      if (!mem_oe_n) begin
        if (mem_ce_n || !mem_we_n) v_rd++;
        if (prev_oe) begin
          acc_in_win++;
          oe_cnt = 0;
          reads++;
          if (pre_cnt < ACC - OEC) v_rd++;
          if (busy_left > 0) begin
            busy_left--;
            rd_val = (mem_addr == busy_addr) ? {~busy_data[7], busy_data[6:0]}
                                             : mem[mem_addr];
          end else begin
            rd_val = mem[mem_addr];
          end
        end
        oe_cnt++;
      end
      if (acc_in_win > 1) v_sb++;
      prev_we   = mem_we_n;
      prev_oe   = mem_oe_n;
      prev_addr = mem_addr;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit            err;
    bit            chk_rd;
    logic [DW-1:0] rd;
    int            reads;
    int            base;
    string         tag;
  } exp_t;

  exp_t sbq[$];

  always @(negedge clk) begin
    if (rst_n && (done || error)) begin
      check(!(done && error), "R10", "done and error together", {done, error}, 0);
      if (sbq.size() == 0) begin
        check(1'b0, "R1", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(error == e.err, e.tag, "error flag", error, e.err);
        check((reads - e.base) == e.reads, e.tag, "device reads", reads - e.base, e.reads);
        if (e.chk_rd) check(rd_data == e.rd, e.tag, "read byte", rd_data, e.rd);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int busy, input bit corr, input bit exp_err,
                        input bit chk_rd, input logic [DW-1:0] exp_rd,
                        input int exp_reads, input string tag);
    exp_t e;
    @(negedge clk);
    busy_cfg = busy;
    corrupt  = corr;
    e.err = exp_err; e.chk_rd = chk_rd; e.rd = exp_rd;
    e.reads = exp_reads; e.base = reads; e.tag = tag;
    sbq.push_back(e);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R1", "ready after accept", req_ready, 0);
    do @(negedge clk); while (!(done || error));
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after response", req_ready, 1);
    check(!done && !error, "R10", "pulse longer than one cycle", {done, error}, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (50000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  // ---------------- sequence ----------------
  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    check(mem_ce_n && mem_oe_n && mem_we_n, "R5", "strobes idle after reset",
          {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    check(!mem_dq_oe, "R5", "bus released after reset", mem_dq_oe, 0);
    check(!done && !error, "R10", "no pulse after reset", {done, error}, 0);

    // R9, R3: single read of preloaded location
    do_req(1'b0, 11'h123, 8'h00, 0, 1'b0, 1'b0, 1'b1, 8'h23 ^ 8'h5A, 1, "R9");
    // R2, R8: write completes at once, one poll plus verify
    do_req(1'b1, 11'h055, 8'h3C, 0, 1'b0, 1'b0, 1'b0, 8'h00, 2, "R8");
    // R6: busy for two reads, bit7 set
    do_req(1'b1, 11'h7FF, 8'h81, 2, 1'b0, 1'b0, 1'b0, 8'h00, 4, "R6");
    // R11: match on the last permitted poll
    do_req(1'b1, 11'h200, 8'h12, MAXP - 1, 1'b0, 1'b0, 1'b0, 8'h00, MAXP + 1, "R11");
    // R7: busy through every poll
    do_req(1'b1, 11'h3A0, 8'h9E, MAXP, 1'b0, 1'b1, 1'b0, 8'h00, MAXP, "R7");
    // R8, R6: bit7 agrees but low bit stored wrong
    do_req(1'b1, 11'h011, 8'hC4, 1, 1'b1, 1'b1, 1'b0, 8'h00, 3, "R8");
    // R9: read back earlier writes
    do_req(1'b0, 11'h7FF, 8'h00, 0, 1'b0, 1'b0, 1'b1, 8'h81, 1, "R9");
    do_req(1'b0, 11'h011, 8'h00, 0, 1'b0, 1'b0, 1'b1, 8'hC5, 1, "R9");
    do_req(1'b0, 11'h200, 8'h00, 0, 1'b0, 1'b0, 1'b1, 8'h12, 1, "R11");
    // R6: bit7 clear, busy once
    do_req(1'b1, 11'h000, 8'h7F, 1, 1'b0, 1'b0, 1'b0, 8'h00, 3, "R6");

    repeat (4) @(negedge clk);
    check(sbq.size() == 0, "R1", "outstanding expectations", sbq.size(), 0);
    check(v_wr == 0,  "R2", "write strobe violations", v_wr, 0);
    check(v_rd == 0,  "R3", "read timing violations", v_rd, 0);
    check(v_bus == 0, "R4", "bus contention cycles", v_bus, 0);
    check(v_sb == 0,  "R5", "accesses sharing a CE window", v_sb, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule